// File: doc/BRIEF.md
# Graphic LCD Register Write Engine

This block is the host-side master for a graphic LCD controller that sits on an 8-bit parallel bus with separate enable, register-select and read/write strobes. A client hands over one request at a time on a valid/ready handshake. Each request carries a 4-bit register code and an 8-bit value. For every accepted request the engine does three things in a fixed order. First it polls the controller's busy flag. Then it writes the register code into the controller's instruction register. Last it writes the value into the selected register. Strobe setup, enable-high width and hold are each a whole number of clock cycles set by parameters, so one design serves any clock rate.

On this controller RS high selects the instruction register, which is the opposite of the usual character-LCD convention. RW low means write, and E is an active-high strobe. During the busy poll only the top data line is released to the pad, and it is driven again once the poll ends. Codes 5, 6 and 7 select no register. Such a request is consumed at once with a one-cycle error pulse and causes no bus cycle. Code 12 writes display data, 13 reads data, 14 clears a bit and 15 sets a bit. The engine passes all of these to the controller in the same way. A watchdog on the busy poll raises a sticky fault flag if the controller stays busy too long. The engine still finishes the transfer once the flag clears.

The controller state machine steps through these states. IDLE goes to BSY_SETUP on a legal request. BSY_SETUP goes to BSY_HIGH after the setup time. BSY_HIGH goes to BSY_DROP_E once the flag reads 0 and the minimum E width has passed. BSY_DROP_E, BSY_DROP_RW and BSY_DROP_RS last one cycle each, and BSY_DROP_RS leads to INS_SETUP. After that come INS_SETUP, INS_HIGH, INS_HOLD, DAT_SETUP, DAT_HIGH and DAT_HOLD, each lasting its parameterised time. DAT_HOLD returns to IDLE.

Top module: `lcdc_regwr_engine`

## Requirements
- R1: Reset state: req_ready=1, lcd_e=0, lcd_rs=0, lcd_rw=0, lcd_db_oe all ones, lcd_db_out=0, req_err=0, busy_fault=0.
- R2: Each accepted request with a legal code (0–4, 8–15) produces exactly three E pulses, in this order: busy poll, instruction write, data write.
- R3: During the busy poll RS=1 and RW=1. Only lcd_db_oe bit 7 is 0 and the other oe bits stay 1. E stays high for max(E_HIGH_CYC, n+1) cycles, where n is the number of consecutive cycles in which lcd_db7_in reads 1.
- R4: The poll ends in this order: E falls, one cycle later RW falls, one cycle after that RS falls and bit 7 is driven again (oe bit 7 = 1).
- R5: Instruction pulse: lcd_db_out = the code zero-extended into bits 3:0, RS=1, RW=0, E high for E_HIGH_CYC cycles. RS stays 1 for HOLD_CYC cycles after E falls.
- R6: Data pulse: lcd_db_out = the request value, RS=0, RW=0, E high for E_HIGH_CYC cycles.
- R7: Each E rise follows SETUP_CYC cycles in which RS, RW and the data lines already hold their pulse values.
- R8: req_ready is 0 from the cycle after acceptance until HOLD_CYC cycles after the data pulse's E falls, and then returns to 1.
- R9: A request with code 5, 6 or 7 is accepted with req_ready held at 1. req_err is 1 for exactly the cycle after acceptance, and no E pulse occurs.
- R10: busy_fault sets if lcd_db7_in reads 1 on BUSY_LIMIT+1 consecutive cycles of one poll, but not at exactly BUSY_LIMIT. Once set it stays set until reset, and the transfer still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_code | input | CODE_W | Register code |
| req_val | input | DATA_W | Value for the register |
| req_err | output | 1 | One-cycle pulse for an unused code |
| lcd_e | output | 1 | Enable strobe, active high |
| lcd_rs | output | 1 | Register select, 1 = instruction register |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_db_out | output | DATA_W | Data lines, output value |
| lcd_db_oe | output | DATA_W | Per-line output enable for the pads |
| lcd_db7_in | input | 1 | Pad input of the top data line (busy flag) |
| busy_fault | output | 1 | Sticky busy-timeout flag |

## Verification
Two functions of this block can act in the same cycle. The busy-flag release ends the poll, and the watchdog decides the fault. With the watchdog limit at 12, one poll holds the flag high for exactly 12 samples, so the first low sample lands in the same cycle the watchdog counter reaches its limit; the fault must stay clear. A second poll holds it high for 13 samples; the fault must set, and the poll must still end normally with three well-formed pulses. The bench judges both outcomes from the fault port and from the logged pin trace of each transfer.

// File: rtl/lcdc_pkg.sv
`timescale 1ns/1ps
package lcdc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BSY_SETUP,
        ST_BSY_HIGH,
        ST_BSY_DROP_E,
        ST_BSY_DROP_RW,
        ST_BSY_DROP_RS,
        ST_INS_SETUP,
        ST_INS_HIGH,
        ST_INS_HOLD,
        ST_DAT_SETUP,
        ST_DAT_HIGH,
        ST_DAT_HOLD
    } wr_state_e;

    typedef enum logic [1:0] {
        BUS_ZERO,
        BUS_CODE,
        BUS_VALUE
    } bus_src_e;

    typedef struct packed {
        logic     e;
        logic     rs;
        logic     rw;
        logic     rel_top;
        bus_src_e src;
    } pin_drive_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lcdc_phase_timer.sv
`timescale 1ns/1ps
module lcdc_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != CNT_TOP) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/lcdc_code_check.sv
`timescale 1ns/1ps
module lcdc_code_check #(
    parameter int unsigned CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic              legal
);

    localparam logic [CODE_W-1:0] GAP_LO = CODE_W'(5);
    localparam logic [CODE_W-1:0] GAP_HI = CODE_W'(7);

    always_comb begin
        legal = (code < GAP_LO) || (code > GAP_HI);
    end

endmodule

// File: rtl/lcdc_busy_watch.sv
`timescale 1ns/1ps
module lcdc_busy_watch #(
    parameter int unsigned LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic polling,
    input  logic flag,
    output logic fault
);

    localparam int unsigned LIM_EFF = (LIMIT < 1) ? 1 : LIMIT;
    localparam int unsigned W       = $clog2(LIM_EFF + 1);
    localparam logic [W-1:0] LIM_V  = W'(LIM_EFF);

    logic [W-1:0] high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_cnt <= '0;
        end else if (!polling) begin
            high_cnt <= '0;
        end else if (flag && high_cnt != LIM_V) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else if (polling && flag && high_cnt == LIM_V) begin
            fault <= 1'b1;
        end
    end

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    p_fault_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(polling && flag));

endmodule

// File: rtl/lcdc_regwr_engine.sv
`timescale 1ns/1ps
module lcdc_regwr_engine
    import lcdc_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned E_HIGH_CYC = 2,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned BUSY_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CODE_W-1:0] req_code,
    input  logic [DATA_W-1:0] req_val,
    output logic              req_err,
    output logic              lcd_e,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic [DATA_W-1:0] lcd_db_out,
    output logic [DATA_W-1:0] lcd_db_oe,
    input  logic              lcd_db7_in,
    output logic              busy_fault
);

    localparam int unsigned SU_EFF = (SETUP_CYC  < 1) ? 1 : SETUP_CYC;
    localparam int unsigned EH_EFF = (E_HIGH_CYC < 1) ? 1 : E_HIGH_CYC;
    localparam int unsigned HO_EFF = (HOLD_CYC   < 1) ? 1 : HOLD_CYC;
    localparam int unsigned CNT_W  = $clog2(max3(SU_EFF, EH_EFF, HO_EFF) + 1);

    localparam logic [CNT_W-1:0] SU_LAST = CNT_W'(SU_EFF - 1);
    localparam logic [CNT_W-1:0] EH_LAST = CNT_W'(EH_EFF - 1);
    localparam logic [CNT_W-1:0] HO_LAST = CNT_W'(HO_EFF - 1);

    wr_state_e         state_q, state_n;
    logic [CNT_W-1:0]  phase_cnt;
    logic              code_legal;
    logic [CODE_W-1:0] code_q;
    logic [DATA_W-1:0] val_q;
    logic              err_q;
    pin_drive_t        drv;
    logic              accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    lcdc_code_check #(.CODE_W(CODE_W)) i_code_check (
        .code  (req_code),
        .legal (code_legal)
    );

    lcdc_phase_timer #(.CNT_W(CNT_W)) i_phase_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_n != state_q),
        .count   (phase_cnt)
    );

    lcdc_busy_watch #(.LIMIT(BUSY_LIMIT)) i_busy_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .polling (state_q == ST_BSY_HIGH),
        .flag    (lcd_db7_in),
        .fault   (busy_fault)
    );

    // next-state decision
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:        if (req_valid && code_legal) state_n = ST_BSY_SETUP;
            ST_BSY_SETUP:   if (phase_cnt == SU_LAST)    state_n = ST_BSY_HIGH;
            ST_BSY_HIGH:    if (!lcd_db7_in && phase_cnt >= EH_LAST) state_n = ST_BSY_DROP_E;
            ST_BSY_DROP_E:  state_n = ST_BSY_DROP_RW;
            ST_BSY_DROP_RW: state_n = ST_BSY_DROP_RS;
            ST_BSY_DROP_RS: state_n = ST_INS_SETUP;
            ST_INS_SETUP:   if (phase_cnt == SU_LAST)    state_n = ST_INS_HIGH;
            ST_INS_HIGH:    if (phase_cnt == EH_LAST)    state_n = ST_INS_HOLD;
            ST_INS_HOLD:    if (phase_cnt == HO_LAST)    state_n = ST_DAT_SETUP;
            ST_DAT_SETUP:   if (phase_cnt == SU_LAST)    state_n = ST_DAT_HIGH;
            ST_DAT_HIGH:    if (phase_cnt == EH_LAST)    state_n = ST_DAT_HOLD;
            ST_DAT_HOLD:    if (phase_cnt == HO_LAST)    state_n = ST_IDLE;
            default:        state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // request capture and error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            val_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= accept && !code_legal;
            if (accept && code_legal) begin
                code_q <= req_code;
                val_q  <= req_val;
            end
        end
    end

    // pin drive per state
    always_comb begin
        drv = '{e: 1'b0, rs: 1'b0, rw: 1'b0, rel_top: 1'b0, src: BUS_ZERO};
        unique case (state_q)
            ST_IDLE:        ;
            ST_BSY_SETUP:   begin drv.rs = 1'b1; drv.rw = 1'b1; drv.rel_top = 1'b1; end
            ST_BSY_HIGH:    begin drv.e = 1'b1; drv.rs = 1'b1; drv.rw = 1'b1; drv.rel_top = 1'b1; end
            ST_BSY_DROP_E:  begin drv.rs = 1'b1; drv.rw = 1'b1; drv.rel_top = 1'b1; end
            ST_BSY_DROP_RW: begin drv.rs = 1'b1; drv.rel_top = 1'b1; end
            ST_BSY_DROP_RS: ;
            ST_INS_SETUP:   begin drv.rs = 1'b1; drv.src = BUS_CODE; end
            ST_INS_HIGH:    begin drv.e = 1'b1; drv.rs = 1'b1; drv.src = BUS_CODE; end
            ST_INS_HOLD:    begin drv.rs = 1'b1; drv.src = BUS_CODE; end
            ST_DAT_SETUP:   drv.src = BUS_VALUE;
            ST_DAT_HIGH:    begin drv.e = 1'b1; drv.src = BUS_VALUE; end
            ST_DAT_HOLD:    drv.src = BUS_VALUE;
            default:        ;
        endcase
    end

    always_comb begin
        lcd_e     = drv.e;
        lcd_rs    = drv.rs;
        lcd_rw    = drv.rw;
        lcd_db_oe = {~drv.rel_top, {(DATA_W-1){1'b1}}};
        unique case (drv.src)
            BUS_CODE:  lcd_db_out = DATA_W'(code_q);
            BUS_VALUE: lcd_db_out = val_q;
            default:   lcd_db_out = '0;
        endcase
        req_ready = (state_q == ST_IDLE);
        req_err   = err_q;
    end

    p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && lcd_rw) |-> (lcd_rs && !lcd_db_oe[DATA_W-1] && (&lcd_db_oe[DATA_W-2:0])));

    p_rw_after_e_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_rw) |-> (!lcd_e && lcd_rs && !$past(lcd_e)));

    p_strobe_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_db_out) && $stable(lcd_rs) && $stable(lcd_rw)));

    p_no_ready_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> !req_ready);

    p_err_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid && req_ready));

    p_err_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!lcd_e && !lcd_rs && !lcd_rw && req_ready));

endmodule

// File: tb/test_lcdc_regwr_engine.sv
`timescale 1ns/1ps
module test_lcdc_regwr_engine;

    localparam int SU  = 2;
    localparam int EH  = 3;
    localparam int HO  = 2;
    localparam int LIM = 12;

    // {code[3:0], value[7:0], busy samples[7:0]}
    localparam logic [19:0] VEC [0:5] = '{
        {4'd0,  8'h3C, 8'd0},
        {4'd1,  8'h77, 8'd2},
        {4'd4,  8'h07, 8'd5},
        {4'd8,  8'h00, 8'd1},
        {4'd12, 8'hA5, 8'd7},
        {4'd15, 8'hFF, 8'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_code = '0;
    logic [7:0] req_val = '0;
    logic       req_err;
    logic       lcd_e, lcd_rs, lcd_rw;
    logic [7:0] lcd_db_out, lcd_db_oe;
    logic       busy7 = 1'b0;
    logic       busy_fault;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int pn = 0;
    int blen_cur = 0;
    int e_seen = 0;
    bit log_en = 1'b0;
    int lg_n = 0;
    logic [11:0] lg [0:255];

    always #2.5 clk = ~clk;

    lcdc_regwr_engine #(
        .DATA_W(8), .CODE_W(4), .SETUP_CYC(SU), .E_HIGH_CYC(EH),
        .HOLD_CYC(HO), .BUSY_LIMIT(LIM)
    ) i_lcdc_regwr_engine (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
        .req_val(req_val), .req_err(req_err),
        .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe),
        .lcd_db7_in(busy7), .busy_fault(busy_fault)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // controller model and pin logger
    always @(negedge clk) begin
        if (lcd_e && lcd_rs && lcd_rw) begin
            pn = pn + 1;
            busy7 <= (pn <= blen_cur);
        end else begin
            pn = 0;
            busy7 <= 1'b0;
        end
        if (lcd_e) e_seen++;
        if (log_en && !req_ready && lg_n < 256) begin
            lg[lg_n] = {lcd_e, lcd_rs, lcd_rw, lcd_db_oe[7], lcd_db_out};
            lg_n++;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-reqs actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic xfer(input logic [3:0] c, input logic [7:0] v, input int bl);
        int nr;
        int rst0 [3];
        int rln [3];
        int w;
        int w0;
        int b;
        int r1;
        int r2;
        bit ok;
        nr = 0;
        rst0 = '{0, 0, 0};
        rln = '{0, 0, 0};
        blen_cur = bl;
        lg_n = 0;
        log_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_code = c; req_val = v;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!req_ready && w < 2000) begin @(negedge clk); w++; end
        log_en = 1'b0;
        for (int i = 0; i < lg_n; i++) begin
            if (lg[i][11] && (i == 0 || !lg[i-1][11])) begin
                if (nr < 3) rst0[nr] = i;
                nr++;
            end
            if (lg[i][11] && nr >= 1 && nr <= 3) rln[nr-1]++;
        end
        check(nr == 3, "R2 pulse count", nr, 3);
        if (nr != 3) return;
        w0 = (EH > bl + 1) ? EH : bl + 1;
        check(rst0[0] == SU, "R7 poll setup", rst0[0], SU);
        check(rln[0] == w0, "R3 poll E width", rln[0], w0);
        ok = 1'b1;
        for (int i = rst0[0]; i < rst0[0] + rln[0]; i++)
            if (lg[i][10:8] != 3'b110) ok = 1'b0;
        check(ok, "R3 poll rs/rw/oe7", ok, 1);
        b = rst0[0] + rln[0];
        check(lg[b][10:8] == 3'b110 && lg[b+1][10:8] == 3'b100 && lg[b+2][10:8] == 3'b001,
              "R4 release order", {lg[b][10:8], lg[b+1][10:8], lg[b+2][10:8]}, 9'b110_100_001);
        r1 = b + 3 + SU;
        check(rst0[1] == r1, "R7 instr setup", rst0[1], r1);
        ok = 1'b1;
        for (int i = b + 3; i < r1 + EH + HO; i++)
            if (lg[i][10:8] != 3'b101 || lg[i][7:0] != {4'h0, c}) ok = 1'b0;
        check(ok, "R5 instr rs/rw/bus", ok, 1);
        check(rln[1] == EH, "R5 instr E width", rln[1], EH);
        r2 = r1 + EH + HO + SU;
        check(rst0[2] == r2, "R7 data setup", rst0[2], r2);
        check(rln[2] == EH, "R6 data E width", rln[2], EH);
        ok = 1'b1;
        for (int i = r1 + EH + HO; i < lg_n; i++)
            if (lg[i][10:8] != 3'b001 || lg[i][7:0] != v) ok = 1'b0;
        check(ok, "R6 data rs/rw/bus", ok, 1);
        check(lg_n == r2 + EH + HO, "R8 ready-low span", lg_n, r2 + EH + HO);
        check(req_ready && !lcd_e, "R8 ready back", req_ready, 1);
    endtask

    task automatic bad_code(input logic [3:0] c);
        e_seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_code = c; req_val = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err === 1'b1 && req_ready === 1'b1, "R9 err pulse", req_err, 1);
        @(negedge clk);
        check(req_err === 1'b0, "R9 err single cycle", req_err, 0);
        repeat (4) @(negedge clk);
        check(e_seen == 0, "R9 no strobe", e_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && lcd_e === 1'b0 && lcd_rs === 1'b0 && lcd_rw === 1'b0,
              "R1 reset pins", {req_ready, lcd_e, lcd_rs, lcd_rw}, 4'b1000);
        check(lcd_db_oe === 8'hFF && lcd_db_out === 8'h00, "R1 reset bus", lcd_db_oe, 8'hFF);
        check(req_err === 1'b0 && busy_fault === 1'b0, "R1 reset flags", {req_err, busy_fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 6; k++)
            xfer(VEC[k][19:16], VEC[k][15:8], int'(VEC[k][7:0]));

        bad_code(4'd5);
        bad_code(4'd6);
        bad_code(4'd7);
        xfer(4'd2, 8'h81, 0);

        xfer(4'd3, 8'h11, LIM);
        check(busy_fault === 1'b0, "R10 exact limit no fault", busy_fault, 0);
        xfer(4'd9, 8'h22, LIM + 1);
        check(busy_fault === 1'b1, "R10 fault over limit", busy_fault, 1);
        xfer(4'd10, 8'h33, 0);
        check(busy_fault === 1'b1, "R10 fault sticky", busy_fault, 1);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy_fault === 1'b0 && req_ready === 1'b1, "R1 R10 reset clears fault", busy_fault, 0);
        rst_n = 1'b1;
        xfer(4'd11, 8'h44, 1);
        check(busy_fault === 1'b0, "R10 clean after reset", busy_fault, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule